// File: doc/BRIEF.md
# Multi-lane SPI data path

This block is the data path of an SPI controller whose serial side is split into several independent one-bit data lanes. Every lane has its own serializer and deserializer, while a single chip select and a single serial clock are shared by all of them. A word stream enters on a valid/ready port for transmit transfers, and received words leave on a second valid/ready port, so one transfer can move several whole words at the same time, one per lane.

A transfer is requested with a one-cycle `start` pulse together with its configuration: the lane mode, the direction, the number of stream words, the word width and one enable mask per direction. In single mode the block behaves like a conventional one-line SPI on lane 0. In stripe mode consecutive stream words are dealt out over the enabled lanes. In mirror mode one transmit word is copied onto every enabled lane. Configurations the data path cannot honour are refused before the chip select is ever asserted.

The serial clock idles low. A lane drives each bit while the clock is low, and the input lines are sampled on the cycle in which the clock is high. One serial bit therefore takes two clock cycles, and words are shifted most significant bit first.

Top module: `mlane_spi_path`

## Requirements
- R1: While reset is held and after it is released, cs_n is 1, sclk is 0, busy, done, err, tx_ready and rx_valid are 0, and every sdo lane sits at idle_level; a reset in the middle of a transfer returns the block to this state.
- R2: In single mode (mode 0) with rx_dir 0, every stream word is sent on sdo[0] only, with its word_bits low bits sent MSB first, one bit per sclk pulse, and all other lanes hold idle_level whatever tx_lane_en holds.
- R3: In single mode with rx_dir 1, only sdi[0] is deserialized: exactly word_count words come out, each being the word_bits bits seen on lane 0 in one word period, and the other lanes have no effect.
- R4: In stripe mode (mode 1) with rx_dir 0, stream word i is sent in word period i/n on the (i mod n)-th enabled lane of tx_lane_en counted from the lowest index, where n is the number of enabled lanes; disabled lanes hold idle_level.
- R5: In stripe mode with rx_dir 1, the words of each word period come out in ascending lane order over the lanes enabled in rx_lane_en, and only after that period's last sclk pulse (with lanes 0 and 1 receiving 0x11 and 0x88, the stream gives 0x11 then 0x88); a word offered while rx_ready is 0 is held unchanged.
- R6: An accepted transfer makes exactly P*word_bits sclk pulses with cs_n low, where P is word_count/n in stripe mode and word_count otherwise.
- R7: In mirror mode (mode 2) with rx_dir 0, every stream word is sent at the same time on every lane enabled in tx_lane_en, and the other lanes hold idle_level.
- R8: A mirror request with rx_dir 1 is refused: done and err rise together one cycle after start, and neither sclk nor cs_n changes.
- R9: The same refusal applies when mode is 3, when word_count is 0, when word_bits is 0 or larger than the maximum width, when stripe or mirror mode has an empty enable mask for its direction, or when in stripe mode word_count is not a multiple of the number of enabled lanes.
- R10: done is a single-cycle pulse that ends each transfer, and busy is 0 in the cycle after it.
- R11: A received word narrower than the maximum width is right-aligned on rx_data, with every bit at or above word_bits equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a transfer when the block is idle |
| mode | input | 2 | 0 single, 1 stripe, 2 mirror, 3 reserved |
| rx_dir | input | 1 | 1 receive transfer, 0 transmit transfer |
| word_count | input | CNTW | Number of stream words in the transfer |
| word_bits | input | $clog2(MAXW+1) | Word width in bits |
| rx_lane_en | input | LANES | Enabled deserializers |
| tx_lane_en | input | LANES | Enabled serializers |
| idle_level | input | 1 | Level held by lanes that are not sending |
| tx_data | input | MAXW | Transmit word, right-aligned |
| tx_valid | input | 1 | Transmit word valid |
| tx_ready | output | 1 | Transmit word accepted when valid |
| rx_data | output | MAXW | Received word, right-aligned |
| rx_valid | output | 1 | Received word valid |
| rx_ready | input | 1 | Consumer accepts the received word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 1 | Transfer refused, valid together with done |
| sclk | output | 1 | Shared serial clock |
| cs_n | output | 1 | Shared chip select, active low |
| sdo | output | LANES | Serial output lines, one per lane |
| sdi | input | LANES | Serial input lines, one per lane |

## Verification
The bench builds the block with four lanes and a 16-bit maximum width. Four lanes let enable masks with holes (lanes 1 and 3, or lane 3 alone) and three-lane groups show that striping follows the mask order rather than raw lane numbers, and that the word count must divide by the enabled count and not by the lane count. The 16-bit width makes both full-width words and short 3- and 5-bit words reachable, which exposes the right alignment of received data. A lane model drives different patterns on every input line, so a word taken from the wrong lane or emitted in the wrong order shows up as a data mismatch.

// File: rtl/mlane_spi_path.sv
module mlane_spi_path #(
  parameter int LANES = 1,
  parameter int MAXW  = 16,
  parameter int CNTW  = 16,
  localparam int BW   = $clog2(MAXW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic             rx_dir,
  input  logic [CNTW-1:0]  word_count,
  input  logic [BW-1:0]    word_bits,
  input  logic [LANES-1:0] rx_lane_en,
  input  logic [LANES-1:0] tx_lane_en,
  input  logic             idle_level,
  input  logic [MAXW-1:0]  tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [MAXW-1:0]  rx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             sclk,
  output logic             cs_n,
  output logic [LANES-1:0] sdo,
  input  logic [LANES-1:0] sdi
);

  localparam int IW = $clog2(MAXW);
  localparam int PW = $clog2(LANES + 1);
  localparam logic [1:0] MD_SINGLE = 2'd0;
  localparam logic [1:0] MD_STRIPE = 2'd1;
  localparam logic [1:0] MD_MIRROR = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_SHIFT, S_EMIT, S_FIN} state_t;

  state_t            st;
  logic [1:0]        mode_q;
  logic              rx_q;
  logic              err_q;
  logic [BW-1:0]     bits_q;
  logic [LANES-1:0]  act;
  logic [CNTW-1:0]   left;
  logic [PW-1:0]     lane_ptr;
  logic [IW-1:0]     bitc;
  logic              phase;
  logic [MAXW-1:0]   txw [LANES];
  logic [MAXW-1:0]   rxw [LANES];

  function automatic int ones(input logic [LANES-1:0] m);
    int c;
    c = 0;
    for (int i = 0; i < LANES; i++) c += int'(m[i]);
    return c;
  endfunction

  function automatic logic [PW-1:0] next_lane(input logic [LANES-1:0] m, input int cur);
    logic [PW-1:0] r;
    r = PW'(LANES);
    for (int i = LANES - 1; i >= 0; i--)
      if (m[i] && i > cur) r = PW'(i);
    return r;
  endfunction

  function automatic logic not_multiple(input logic [CNTW-1:0] c, input int n);
    logic r;
    r = 1'b0;
    for (int k = 1; k <= LANES; k++)
      if (n == k && (c % k) != 0) r = 1'b1;
    return r;
  endfunction

  logic [LANES-1:0] sel_mask, new_act;
  logic [PW-1:0]    nxt_lane, new_first, act_first;
  logic             bad_cfg;
  int               n_sel;

  assign sel_mask  = rx_dir ? rx_lane_en : tx_lane_en;
  assign n_sel     = ones(sel_mask);
  assign new_act   = (mode == MD_SINGLE) ? LANES'(1) : sel_mask;
  assign new_first = next_lane(new_act, -1);
  assign act_first = next_lane(act, -1);
  assign nxt_lane  = next_lane(act, int'(lane_ptr));

  assign bad_cfg = (mode == 2'd3) || (mode == MD_MIRROR && rx_dir) ||
                   (word_count == '0) || (word_bits == '0) ||
                   (int'(word_bits) > MAXW) ||
                   (mode != MD_SINGLE && n_sel == 0) ||
                   (mode == MD_STRIPE && not_multiple(word_count, n_sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      mode_q   <= MD_SINGLE;
      rx_q     <= 1'b0;
      err_q    <= 1'b0;
      bits_q   <= '0;
      act      <= '0;
      left     <= '0;
      lane_ptr <= '0;
      bitc     <= '0;
      phase    <= 1'b0;
      for (int l = 0; l < LANES; l++) begin
        txw[l] <= '0;
        rxw[l] <= '0;
      end
    end else begin
      case (st)
        S_IDLE: if (start) begin
          mode_q <= mode;
          rx_q   <= rx_dir;
          bits_q <= word_bits;
          left   <= word_count;
          act    <= new_act;
          err_q  <= bad_cfg;
          phase  <= 1'b0;
          bitc   <= IW'(int'(word_bits) - 1);
          lane_ptr <= new_first;
          for (int l = 0; l < LANES; l++) rxw[l] <= '0;
          if (bad_cfg)     st <= S_FIN;
          else if (rx_dir) st <= S_SHIFT;
          else             st <= S_LOAD;
        end
        S_LOAD: if (tx_valid) begin
          left <= left - 1'b1;
          for (int l = 0; l < LANES; l++)
            if ((mode_q == MD_MIRROR) ? act[l] : (PW'(l) == lane_ptr)) txw[l] <= tx_data;
          if (mode_q == MD_MIRROR || nxt_lane == PW'(LANES)) begin
            st    <= S_SHIFT;
            bitc  <= IW'(int'(bits_q) - 1);
            phase <= 1'b0;
          end else begin
            lane_ptr <= nxt_lane;
          end
        end
        S_SHIFT: begin
          phase <= ~phase;
          if (phase) begin
            if (rx_q)
              for (int l = 0; l < LANES; l++)
                if (act[l]) rxw[l] <= {rxw[l][MAXW-2:0], sdi[l]};
            if (bitc == '0) begin
              lane_ptr <= act_first;
              if (rx_q)             st <= S_EMIT;
              else if (left == '0)  st <= S_FIN;
              else                  st <= S_LOAD;
            end else begin
              bitc <= bitc - 1'b1;
            end
          end
        end
        S_EMIT: if (rx_ready) begin
          left <= left - 1'b1;
          if (nxt_lane == PW'(LANES)) begin
            if (left == CNTW'(1)) begin
              st <= S_FIN;
            end else begin
              st    <= S_SHIFT;
              bitc  <= IW'(int'(bits_q) - 1);
              phase <= 1'b0;
              for (int l = 0; l < LANES; l++) rxw[l] <= '0;
            end
          end else begin
            lane_ptr <= nxt_lane;
          end
        end
        default: begin
          st    <= S_IDLE;
          err_q <= 1'b0;
        end
      endcase
    end
  end

  logic [MAXW-1:0] rx_word;
  always_comb begin
    rx_word = '0;
    for (int l = 0; l < LANES; l++)
      if (PW'(l) == lane_ptr) rx_word = rxw[l];
  end

  assign busy     = (st != S_IDLE);
  assign done     = (st == S_FIN);
  assign err      = (st == S_FIN) && err_q;
  assign tx_ready = (st == S_LOAD);
  assign rx_valid = (st == S_EMIT);
  assign rx_data  = rx_valid ? rx_word : '0;
  assign sclk     = (st == S_SHIFT) && phase;
  assign cs_n     = !(st == S_LOAD || st == S_SHIFT || st == S_EMIT);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign sdo[g] = (st == S_SHIFT && !rx_q && act[g]) ? txw[g][bitc] : idle_level;
  end

  p_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && bad_cfg) |=> (done && err));

  p_mirror_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && rx_dir && mode == MD_MIRROR) |=> (err && cs_n && !sclk));

  p_rx_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (!sclk && !cs_n));

  p_rx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  p_width_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ((rx_data >> bits_q) == '0));

endmodule

// File: tb/tb_mlane_spi_path.sv
`timescale 1ns/1ps
module tb_mlane_spi_path;

  localparam int LANES = 4;
  localparam int MAXW  = 16;
  localparam int CNTW  = 16;
  localparam int BW    = $clog2(MAXW + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] mode = '0;
  logic rx_dir = 1'b0;
  logic [CNTW-1:0] word_count = '0;
  logic [BW-1:0] word_bits = '0;
  logic [LANES-1:0] rx_lane_en = '0, tx_lane_en = '0;
  logic idle_level = 1'b0;
  logic [MAXW-1:0] tx_data = '0;
  logic tx_valid = 1'b0;
  logic tx_ready;
  logic [MAXW-1:0] rx_data;
  logic rx_valid;
  logic rx_ready = 1'b0;
  logic busy, done, err, sclk, cs_n;
  logic [LANES-1:0] sdo, sdi;

  always #10 clk = ~clk;

  mlane_spi_path #(.LANES(LANES), .MAXW(MAXW), .CNTW(CNTW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .rx_dir(rx_dir),
    .word_count(word_count), .word_bits(word_bits), .rx_lane_en(rx_lane_en),
    .tx_lane_en(tx_lane_en), .idle_level(idle_level), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .busy(busy), .done(done), .err(err), .sclk(sclk),
    .cs_n(cs_n), .sdo(sdo), .sdi(sdi));

  typedef struct packed {
    logic [1:0] md;
    logic       rx;
    logic [7:0] cnt;
    logic [4:0] bits;
    logic [3:0] mask;
    logic       idle;
    logic       xerr;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 8'd3, 5'd8,  4'hF, 1'b1, 1'b0},
    '{2'd0, 1'b1, 8'd2, 5'd8,  4'hF, 1'b0, 1'b0},
    '{2'd0, 1'b1, 8'd4, 5'd3,  4'h0, 1'b1, 1'b0},
    '{2'd1, 1'b1, 8'd8, 5'd12, 4'hF, 1'b0, 1'b0},
    '{2'd1, 1'b1, 8'd4, 5'd16, 4'hA, 1'b1, 1'b0},
    '{2'd1, 1'b0, 8'd8, 5'd8,  4'hF, 1'b1, 1'b0},
    '{2'd1, 1'b0, 8'd6, 5'd5,  4'h7, 1'b0, 1'b0},
    '{2'd2, 1'b0, 8'd2, 5'd10, 4'hD, 1'b0, 1'b0},
    '{2'd2, 1'b1, 8'd2, 5'd8,  4'hF, 1'b1, 1'b1},
    '{2'd1, 1'b0, 8'd5, 5'd8,  4'hF, 1'b1, 1'b1},
    '{2'd1, 1'b1, 8'd3, 5'd8,  4'h3, 1'b0, 1'b1},
    '{2'd3, 1'b0, 8'd2, 5'd8,  4'hF, 1'b1, 1'b1},
    '{2'd1, 1'b0, 8'd4, 5'd8,  4'h0, 1'b1, 1'b1},
    '{2'd0, 1'b0, 8'd2, 5'd0,  4'hF, 1'b1, 1'b1},
    '{2'd1, 1'b1, 8'd3, 5'd16, 4'h8, 1'b0, 1'b0}
  };

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // Lane model and bus monitor
  logic [15:0] pat [LANES][8];
  logic [15:0] cap_log [LANES][8];
  logic [15:0] cap_sh [LANES];
  int cap_n [LANES];
  int cap_k [LANES];
  logic [LANES-1:0] used_tx = '0;
  int cur_bits = 8;
  int pk = 0, pb = 7;
  int rises = 0, cs_low = 0, idle_bad = 0;
  logic prev_sclk = 1'b0;

  always_comb
    for (int l = 0; l < LANES; l++) sdi[l] = pat[l][pk & 7][pb & 15];

  always @(negedge clk) begin
    if (cs_n) begin
      pk = 0;
      pb = cur_bits - 1;
    end else if (prev_sclk && !sclk) begin
      if (pb <= 0) begin pk = pk + 1; pb = cur_bits - 1; end
      else pb = pb - 1;
    end
    if (!cs_n) cs_low++;
    if (sclk && !prev_sclk) begin
      rises++;
      for (int l = 0; l < LANES; l++) begin
        if (used_tx[l]) begin
          cap_sh[l] = {cap_sh[l][14:0], sdo[l]};
          cap_n[l]++;
          if (cap_n[l] == cur_bits) begin
            if (cap_k[l] < 8) cap_log[l][cap_k[l]] = cap_sh[l];
            cap_k[l]++;
            cap_n[l] = 0;
            cap_sh[l] = '0;
          end
        end else if (sdo[l] !== idle_level) begin
          idle_bad++;
        end
      end
    end
    prev_sclk = sclk;
  end

  function automatic logic [15:0] wmask(input int b);
    return (b >= 16) ? 16'hFFFF : 16'((32'd1 << b) - 1);
  endfunction

  function automatic logic [15:0] patf(input int l, input int k, input int b);
    logic [31:0] v;
    v = (32'hA5C3 ^ (32'h1111 * (l + 1))) + 32'h0737 * k + 32'h29 * l * k;
    return v[15:0] & wmask(b);
  endfunction

  function automatic logic [15:0] txf(input int i, input int b);
    logic [31:0] v;
    v = (32'h3C5A + 32'h01B3 * i) ^ (i << 3);
    return v[15:0] & wmask(b);
  endfunction

  function automatic string req_of(input vec_t v);
    if (v.xerr) return (v.md == 2'd2 && v.rx) ? "R8" : "R9";
    case (v.md)
      2'd0: return v.rx ? "R3" : "R2";
      2'd1: return v.rx ? "R5" : "R4";
      default: return "R7";
    endcase
  endfunction

  task automatic run(input vec_t v, input bit keep_pat);
    int n, per, nexp, nfeed, stall;
    int lanes_on [4];
    logic [15:0] exp_rx [32];
    logic [15:0] got_rx [32];
    logic [15:0] exp_tx [LANES][8];
    int exp_tn [LANES];
    logic got_err;
    string rq;
    rq = req_of(v);
    n = 0;
    for (int l = 0; l < LANES; l++) if (v.mask[l]) begin lanes_on[n] = l; n++; end
    if (!keep_pat)
      for (int l = 0; l < LANES; l++)
        for (int k = 0; k < 8; k++) pat[l][k] = patf(l, k, int'(v.bits));
    for (int l = 0; l < LANES; l++) begin
      cap_n[l] = 0; cap_k[l] = 0; cap_sh[l] = '0; exp_tn[l] = 0;
    end
    per = (v.md == 2'd1 && n > 0) ? int'(v.cnt) / n : int'(v.cnt);
    nexp = 0;
    if (v.rx && !v.xerr) begin
      if (v.md == 2'd0)
        for (int p = 0; p < int'(v.cnt); p++) begin exp_rx[nexp] = pat[0][p]; nexp++; end
      else
        for (int p = 0; p < per; p++)
          for (int j = 0; j < n; j++) begin exp_rx[nexp] = pat[lanes_on[j]][p]; nexp++; end
    end
    nfeed = (!v.rx && !v.xerr) ? int'(v.cnt) : 0;
    for (int i = 0; i < nfeed; i++) begin
      if (v.md == 2'd0) begin
        exp_tx[0][exp_tn[0]] = txf(i, int'(v.bits)); exp_tn[0]++;
      end else if (v.md == 2'd1) begin
        exp_tx[lanes_on[i % n]][i / n] = txf(i, int'(v.bits)); exp_tn[lanes_on[i % n]]++;
      end else begin
        for (int j = 0; j < n; j++) begin
          exp_tx[lanes_on[j]][i] = txf(i, int'(v.bits)); exp_tn[lanes_on[j]]++;
        end
      end
    end
    used_tx = (v.rx || v.xerr) ? 4'h0 : ((v.md == 2'd0) ? 4'h1 : v.mask);
    cur_bits = int'(v.bits);
    @(negedge clk);
    rises = 0; cs_low = 0; idle_bad = 0;
    mode = v.md; rx_dir = v.rx; word_count = CNTW'(v.cnt); word_bits = BW'(v.bits);
    rx_lane_en = v.mask; tx_lane_en = v.mask; idle_level = v.idle;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got_err = 1'b0;
    stall = 0;
    fork
      begin
        for (int i = 0; i < nfeed; i++) begin
          if (i > 0) @(negedge clk);
          tx_valid = 1'b1;
          tx_data = txf(i, int'(v.bits)) | (16'hFFFF & ~wmask(int'(v.bits)));
          while (!tx_ready) @(negedge clk);
        end
        if (nfeed > 0) begin @(negedge clk); tx_valid = 1'b0; end
      end
      begin
        int j = 0;
        while (j < nexp) begin
          rx_ready = ((stall % 3) != 2);
          stall++;
          if (rx_valid && rx_ready) begin got_rx[j] = rx_data; j++; end
          @(negedge clk);
        end
        rx_ready = 1'b0;
      end
      begin
        while (!done) @(negedge clk);
        got_err = err;
      end
    join
    check(rq, "err flag with done", got_err, v.xerr);
    @(negedge clk);
    check("R10", "done and busy after end", {done, busy}, 2'b00);
    if (v.xerr) begin
      check(rq, "sclk pulses on refused transfer", rises, 0);
      check(rq, "cs_n low cycles on refused transfer", cs_low, 0);
    end else begin
      check("R6", "sclk pulse count", rises, per * int'(v.bits));
      check(rq, "idle level on unused lanes", idle_bad, 0);
      for (int j = 0; j < nexp; j++) begin
        check(rq, $sformatf("rx word %0d", j), got_rx[j], exp_rx[j]);
        check("R11", $sformatf("rx word %0d upper bits", j),
              got_rx[j] & ~wmask(int'(v.bits)), 0);
      end
      for (int l = 0; l < LANES; l++) begin
        check(rq, $sformatf("tx words on lane %0d", l), cap_k[l], exp_tn[l]);
        for (int k = 0; k < exp_tn[l] && k < 8; k++)
          check(rq, $sformatf("tx lane %0d word %0d", l, k), cap_log[l][k], exp_tx[l][k]);
      end
    end
  endtask

  task automatic reset_state_check(input string what);
    check("R1", what, {cs_n, sclk, busy, done, err, tx_ready, rx_valid}, 7'b1000000);
    check("R1", {what, " sdo"}, sdo, {LANES{idle_level}});
  endtask

  initial begin
    for (int l = 0; l < LANES; l++)
      for (int k = 0; k < 8; k++) begin pat[l][k] = '0; cap_log[l][k] = '0; end
    idle_level = 1'b1;
    repeat (3) @(negedge clk);
    reset_state_check("during reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    reset_state_check("after reset");

    for (int i = 0; i < NV; i++) run(VECS[i], 1'b0);

    // reset in the middle of a receive transfer (R1)
    @(negedge clk);
    idle_level = 1'b0;
    mode = 2'd1; rx_dir = 1'b1; word_count = 16'd8; word_bits = BW'(12);
    rx_lane_en = 4'hF; tx_lane_en = 4'hF; cur_bits = 12;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (9) @(negedge clk);
    check("R1", "cs_n low before mid-transfer reset", cs_n, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    reset_state_check("mid-transfer reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    reset_state_check("after mid-transfer reset");

    // two-lane stripe receive ordering example (R5)
    for (int l = 0; l < LANES; l++)
      for (int k = 0; k < 8; k++) pat[l][k] = 16'h00FF;
    pat[0][0] = 16'h0011;
    pat[1][0] = 16'h0088;
    run('{2'd1, 1'b1, 8'd2, 5'd8, 4'h3, 1'b0, 1'b0}, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule